// File: doc/BRIEF.md
# Processor State Change Unit

This block executes the instruction that changes the processor's interrupt masks and, optionally, its operating mode. It accepts the instruction in any of three encodings: a fixed-width 32-bit word, a 16-bit compressed halfword, or a 32-bit compressed word made of two halfwords. A select input tells it which encoding it has. It decodes the fields and rejects reserved field combinations. It then updates a small architectural state register, which holds three interrupt masks (asynchronous abort, normal interrupt, fast interrupt), a 5-bit mode, a privilege indication and a sticky illegal-state flag.

The surrounding core presents one instruction per cycle with a valid strobe and reports whether the instruction sits inside a conditional-execution block. The unit answers combinationally with an undefined-instruction flag, or with a hint-space flag when the compressed 32-bit word actually encodes a hint. A legal update commits at the clock edge that ends the valid cycle. At the unprivileged level every well-formed instruction is accepted but has no effect. A write of an unsupported mode value does not change the mode. It raises the illegal-state flag instead.

Top module: `state_change_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first update, `mask_o` is 3'b111, `mode_o` is 5'h13, `priv_o` is 1 and `illegal_o` is 0.
- R2: `fmt_i` selects the encoding: 0 fixed 32-bit, 1 16-bit in `instr_i[15:0]`, 2 compressed 32-bit with the first halfword in `instr_i[31:16]`. A value of 3, or a word whose fixed bits do not match, raises `undef_o`.
- R3: Fixed form: bits 31:20 = 12'hF10, bit 16 = 0, bit 5 = 0. The operation code is in 19:18, the change-mode bit in 17, the mask select (abort, interrupt, fast) in 8:6 and the mode in 4:0.
- R4: 16-bit form: bits 15:6 = 10'b1011011001 and bit 5 = 1. Bit 4 set means mask and clear means unmask. Bits 2:0 select the masks. This form never writes the mode.
- R5: Compressed 32-bit form: bits 31:20 = 12'b111100111010 and bits 15:11 = 5'b10000. The operation code is in 10:9, the change-mode bit in 8, the mask select in 7:5 and the mode in 4:0.
- R6: Operation code 2'b10 clears each selected mask bit and 2'b11 sets it. Bits that are not selected keep their value. The update lands at the rising edge that ends the valid cycle.
- R7: With the change-mode bit set, a legal mode (0x10, 0x11, 0x12, 0x13, 0x17, 0x1B, 0x1F) is written to `mode_o`. `priv_o` becomes 0 exactly when the mode is 0x10.
- R8: With the change-mode bit set, an illegal mode value leaves `mode_o` unchanged and sets `illegal_o`, which stays set until reset. The mask update of the same instruction still applies.
- R9: While `priv_o` is 0, no instruction changes any state bit.
- R10: The following combinations raise `undef_o` and leave the state unchanged: operation code 2'b01; operation code 2'b00 with the change-mode bit clear in the fixed form; operation code bit 1 set with an empty mask select; operation code bit 1 clear with a non-empty mask select; an empty mask select in the 16-bit form.
- R11: In the compressed 32-bit form, operation code 2'b00 with the change-mode bit clear raises `hint_o` rather than `undef_o` and changes no state.
- R12: A nonzero mode field with the change-mode bit clear is not undefined. The mask update executes and the mode field is ignored.
- R13: With `cond_blk_i` high, both compressed forms are undefined. The fixed form is unaffected by it.
- R14: With `valid_i` low, both flags are 0 and all state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Instruction present this cycle |
| fmt_i | input | 2 | Encoding select |
| instr_i | input | 32 | Instruction word |
| cond_blk_i | input | 1 | Instruction lies inside a conditional-execution block |
| mask_o | output | 3 | Masks: bit 2 abort, bit 1 interrupt, bit 0 fast interrupt |
| mode_o | output | 5 | Current mode |
| priv_o | output | 1 | 1 when privileged |
| illegal_o | output | 1 | Sticky illegal-state flag |
| undef_o | output | 1 | Current instruction is undefined |
| hint_o | output | 1 | Current instruction lies in hint space |

## Verification
The assertions assume that `valid_i` and `fmt_i` are driven to known values whenever reset is released, and that stimulus starts only after the internal reset release has finished. The bench changes inputs only on falling edges, with every input driven. It waits out the synchronizer delay after each reset. Random words are built from legal templates with occasional single-bit corruptions, so that reserved, hint and pattern-mismatch cases occur alongside normal updates. The bench reapplies reset shortly after the model drops privilege, so the run does not stay frozen at the unprivileged level.

// File: rtl/scu_pkg.sv
`timescale 1ns/1ps
package scu_pkg;
  localparam int SCU_MODE_W = 5;
  localparam int SCU_NMASK  = 3;
  localparam logic [SCU_MODE_W-1:0] SCU_USER_MODE  = 5'h10;
  localparam logic [SCU_MODE_W-1:0] SCU_RESET_MODE = 5'h13;

  typedef enum logic [1:0] {
    FMT_WIDE  = 2'd0,
    FMT_SHORT = 2'd1,
    FMT_PAIR  = 2'd2,
    FMT_RSVD  = 2'd3
  } scu_fmt_e;

  typedef struct packed {
    logic [SCU_NMASK-1:0]  mask;
    logic [SCU_MODE_W-1:0] mode;
    logic                  priv;
    logic                  illegal;
  } scu_state_t;

  function automatic logic scu_mode_legal(input logic [SCU_MODE_W-1:0] m);
    case (m)
      5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/scu_extract.sv
`timescale 1ns/1ps
module scu_extract
  import scu_pkg::*;
#(
  parameter int NMASK  = SCU_NMASK,
  parameter int MODE_W = SCU_MODE_W
) (
  input  logic [31:0]       instr_i,
  input  logic [1:0]        fmt_i,
  output logic              match_o,
  output logic [1:0]        op_o,
  output logic              chg_o,
  output logic [NMASK-1:0]  sel_o,
  output logic [MODE_W-1:0] mode_o
);
  always_comb begin
    match_o = 1'b0;
    op_o    = 2'b00;
    chg_o   = 1'b0;
    sel_o   = '0;
    mode_o  = '0;
    case (fmt_i)
      FMT_WIDE: begin
        match_o = (instr_i[31:20] == 12'hF10) && !instr_i[16] && !instr_i[5];
        op_o    = instr_i[19:18];
        chg_o   = instr_i[17];
        sel_o   = instr_i[8:6];
        mode_o  = instr_i[4:0];
      end
      FMT_SHORT: begin
        match_o = (instr_i[15:6] == 10'b1011011001) && instr_i[5];
        op_o    = {1'b1, instr_i[4]};
        chg_o   = 1'b0;
        sel_o   = instr_i[2:0];
        mode_o  = '0;
      end
      FMT_PAIR: begin
        match_o = (instr_i[31:20] == 12'b111100111010) && (instr_i[15:11] == 5'b10000);
        op_o    = instr_i[10:9];
        chg_o   = instr_i[8];
        sel_o   = instr_i[7:5];
        mode_o  = instr_i[4:0];
      end
      default: match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/scu_policy.sv
`timescale 1ns/1ps
module scu_policy
  import scu_pkg::*;
#(
  parameter int NMASK = SCU_NMASK
) (
  input  logic             valid_i,
  input  logic [1:0]       fmt_i,
  input  logic             cond_blk_i,
  input  logic             priv_i,
  input  logic             match_i,
  input  logic [1:0]       op_i,
  input  logic             chg_i,
  input  logic [NMASK-1:0] sel_i,
  output logic             undef_o,
  output logic             hint_o,
  output logic             exec_o
);
  logic is_hint, reserved;

  always_comb begin
    is_hint  = match_i && (fmt_i == FMT_PAIR) && (op_i == 2'b00) && !chg_i;
    reserved = !match_i
            || (op_i == 2'b01)
            || ((fmt_i == FMT_WIDE) && (op_i == 2'b00) && !chg_i)
            || (op_i[1] && (sel_i == '0))
            || (!op_i[1] && (sel_i != '0))
            || ((fmt_i != FMT_WIDE) && cond_blk_i);
    hint_o   = valid_i && is_hint;
    undef_o  = valid_i && reserved && !is_hint;
    exec_o   = valid_i && !reserved && !is_hint && priv_i;
  end
endmodule

// File: rtl/scu_next.sv
`timescale 1ns/1ps
module scu_next
  import scu_pkg::*;
#(
  parameter int NMASK  = SCU_NMASK,
  parameter int MODE_W = SCU_MODE_W
) (
  input  scu_state_t        cur_i,
  input  logic              exec_i,
  input  logic [1:0]        op_i,
  input  logic              chg_i,
  input  logic [NMASK-1:0]  sel_i,
  input  logic [MODE_W-1:0] mode_i,
  output scu_state_t        nxt_o
);
  logic [NMASK-1:0] mask_n;
  logic             mode_ok;

  // Each mask bit takes the operation's polarity only when selected.
  for (genvar g = 0; g < NMASK; g++) begin : g_mask
    always_comb begin
      mask_n[g] = cur_i.mask[g];
      if (exec_i && op_i[1] && sel_i[g]) mask_n[g] = op_i[0];
    end
  end

  always_comb begin
    mode_ok      = scu_mode_legal(mode_i);
    nxt_o        = cur_i;
    nxt_o.mask   = mask_n;
    if (exec_i && chg_i) begin
      if (mode_ok) begin
        nxt_o.mode = mode_i;
        nxt_o.priv = (mode_i != SCU_USER_MODE);
      end else begin
        nxt_o.illegal = 1'b1;
      end
    end
  end
endmodule

// File: rtl/state_change_unit.sv
`timescale 1ns/1ps
module state_change_unit
  import scu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [1:0]  fmt_i,
  input  logic [31:0] instr_i,
  input  logic        cond_blk_i,
  output logic [2:0]  mask_o,
  output logic [4:0]  mode_o,
  output logic        priv_o,
  output logic        illegal_o,
  output logic        undef_o,
  output logic        hint_o
);
  localparam int NMASK  = SCU_NMASK;
  localparam int MODE_W = SCU_MODE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              match, chg, exec;
  logic [1:0]        op;
  logic [NMASK-1:0]  sel;
  logic [MODE_W-1:0] fmode;
  scu_state_t        state_q, state_d;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scu_extract #(.NMASK(NMASK), .MODE_W(MODE_W)) u_extract (
    .instr_i (instr_i),
    .fmt_i   (fmt_i),
    .match_o (match),
    .op_o    (op),
    .chg_o   (chg),
    .sel_o   (sel),
    .mode_o  (fmode)
  );

  scu_policy #(.NMASK(NMASK)) u_policy (
    .valid_i    (valid_i),
    .fmt_i      (fmt_i),
    .cond_blk_i (cond_blk_i),
    .priv_i     (state_q.priv),
    .match_i    (match),
    .op_i       (op),
    .chg_i      (chg),
    .sel_i      (sel),
    .undef_o    (undef_o),
    .hint_o     (hint_o),
    .exec_o     (exec)
  );

  scu_next #(.NMASK(NMASK), .MODE_W(MODE_W)) u_next (
    .cur_i  (state_q),
    .exec_i (exec),
    .op_i   (op),
    .chg_i  (chg),
    .sel_i  (sel),
    .mode_i (fmode),
    .nxt_o  (state_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q.mask    <= '1;
      state_q.mode    <= SCU_RESET_MODE;
      state_q.priv    <= 1'b1;
      state_q.illegal <= 1'b0;
    end else if (exec) begin
      state_q <= state_d;
    end
  end

  assign mask_o    = state_q.mask;
  assign mode_o    = state_q.mode;
  assign priv_o    = state_q.priv;
  assign illegal_o = state_q.illegal;
endmodule

// File: rtl/scu_checker.sv
`timescale 1ns/1ps
module scu_checker
  import scu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic [1:0] fmt_i,
  input logic [2:0] mask_o,
  input logic [4:0] mode_o,
  input logic       priv_o,
  input logic       illegal_o,
  input logic       undef_o,
  input logic       hint_o
);
  logic [9:0] st;
  assign st = {mask_o, mode_o, priv_o, illegal_o};

  assert_hold_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(st));
  assert_flags_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !undef_o && !hint_o);
  assert_undef_nochange_R10: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |=> $stable(st));
  assert_user_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_o |=> $stable(st));
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_o && hint_o));
  assert_hint_pair_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hint_o |-> (fmt_i == FMT_PAIR));
  assert_hint_nochange_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hint_o |=> $stable(st));
  assert_illegal_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal_o) |-> $past(valid_i) && $stable(mode_o));
  assert_illegal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> illegal_o);
  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scu_mode_legal(mode_o));
  assert_priv_tracks_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_o == (mode_o != SCU_USER_MODE));
endmodule

bind state_change_unit scu_checker u_scu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .fmt_i     (fmt_i),
  .mask_o    (mask_o),
  .mode_o    (mode_o),
  .priv_o    (priv_o),
  .illegal_o (illegal_o),
  .undef_o   (undef_o),
  .hint_o    (hint_o)
);

// File: tb/state_change_unit_bench.sv
`timescale 1ns/1ps
module state_change_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  fmt_i;
  logic [31:0] instr_i;
  logic        cond_blk_i;
  logic [2:0]  mask_o;
  logic [4:0]  mode_o;
  logic        priv_o, illegal_o, undef_o, hint_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected state
  logic [2:0] e_mask;
  logic [4:0] e_mode;
  logic       e_priv, e_ill;

  always #2.5 clk = ~clk;

  state_change_unit u_state_change_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fmt_i(fmt_i),
    .instr_i(instr_i), .cond_blk_i(cond_blk_i), .mask_o(mask_o),
    .mode_o(mode_o), .priv_o(priv_o), .illegal_o(illegal_o),
    .undef_o(undef_o), .hint_o(hint_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_wide(input logic [1:0] op, input logic c, input logic [2:0] s, input logic [4:0] m);
    return {12'hF10, op, c, 1'b0, 7'b0, s, 1'b0, m};
  endfunction
  function automatic logic [31:0] mk_short(input logic im, input logic [2:0] s);
    return {16'h0, 10'b1011011001, 1'b1, im, 1'b0, s};
  endfunction
  function automatic logic [31:0] mk_pair(input logic [1:0] op, input logic c, input logic [2:0] s, input logic [4:0] m);
    return {12'b111100111010, 4'b1111, 5'b10000, op, c, s, m};
  endfunction

  function automatic bit legal_mode(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  // Model of the decode from the requirements; returns a tag for messages.
  task automatic model(input logic [31:0] w, input logic [1:0] f, input logic cd, input logic v,
                       output logic u, output logic h, output logic x,
                       output logic [1:0] op, output logic c, output logic [2:0] s,
                       output logic [4:0] m, output string tag);
    logic ok, rsv;
    ok = 0; op = 0; c = 0; s = 0; m = 0;
    if (f == 2'd0) begin       // R3
      ok = w[31:20] == 12'hF10 && w[16] == 0 && w[5] == 0;
      op = w[19:18]; c = w[17]; s = w[8:6]; m = w[4:0];
    end else if (f == 2'd1) begin  // R4
      ok = w[15:6] == 10'b1011011001 && w[5];
      op = {1'b1, w[4]}; s = w[2:0];
    end else if (f == 2'd2) begin  // R5
      ok = w[31:20] == 12'b111100111010 && w[15:11] == 5'b10000;
      op = w[10:9]; c = w[8]; s = w[7:5]; m = w[4:0];
    end
    h = v && ok && f == 2'd2 && op == 2'b00 && !c;
    rsv = !ok || op == 2'b01 || (f == 2'd0 && op == 2'b00 && !c) ||
          (op[1] && s == 0) || (!op[1] && s != 0) || (f != 2'd0 && cd);
    u = v && rsv && !h;
    x = v && !rsv && !h && e_priv;
    if (!v) tag = "R14";
    else if (h) tag = "R11";
    else if (!ok) tag = "R2";
    else if (rsv && f != 2'd0 && cd) tag = "R13";
    else if (rsv) tag = "R10";
    else if (!e_priv) tag = "R9";
    else if (c && !legal_mode(m)) tag = "R8";
    else if (c) tag = "R7";
    else if (m != 0) tag = "R12";
    else tag = "R6";
  endtask

  task automatic step(input logic [31:0] w, input logic [1:0] f, input logic cd, input logic v);
    logic u, h, x, c;
    logic [1:0] op;
    logic [2:0] s;
    logic [4:0] m;
    string tag, ftag;
    @(negedge clk);
    instr_i = w; fmt_i = f; cond_blk_i = cd; valid_i = v;
    #1;
    model(w, f, cd, v, u, h, x, op, c, s, m, tag);
    ftag = (f == 2'd0) ? "R3" : (f == 2'd1) ? "R4" : (f == 2'd2) ? "R5" : "R2";
    chk(undef_o == u, $sformatf("%s/%s undef", tag, ftag), {31'b0, undef_o}, {31'b0, u});
    chk(hint_o == h,  $sformatf("%s/%s hint", tag, ftag), {31'b0, hint_o}, {31'b0, h});
    if (x) begin
      for (int i = 0; i < 3; i++) if (s[i] && op[1]) e_mask[i] = op[0];
      if (c) begin
        if (legal_mode(m)) begin e_mode = m; e_priv = (m != 5'h10); end
        else e_ill = 1'b1;
      end
    end
    @(posedge clk); #1;
    chk({mask_o, mode_o, priv_o, illegal_o} == {e_mask, e_mode, e_priv, e_ill},
        $sformatf("%s/%s state", tag, ftag),
        {22'b0, mask_o, mode_o, priv_o, illegal_o}, {22'b0, e_mask, e_mode, e_priv, e_ill});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid_i = 1'b0;
    e_mask = 3'b111; e_mode = 5'h13; e_priv = 1'b1; e_ill = 1'b0;
    #1;
    chk({mask_o, mode_o, priv_o, illegal_o} == {3'b111, 5'h13, 2'b10}, "R1 in reset",
        {22'b0, mask_o, mode_o, priv_o, illegal_o}, {22'b0, 3'b111, 5'h13, 2'b10});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({mask_o, mode_o, priv_o, illegal_o} == {3'b111, 5'h13, 2'b10}, "R1 after release",
        {22'b0, mask_o, mode_o, priv_o, illegal_o}, {22'b0, 3'b111, 5'h13, 2'b10});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int user_wait;
    void'($urandom(32'd7919));
    rst_n = 1'b1; valid_i = 0; fmt_i = 0; instr_i = 0; cond_blk_i = 0;
    #1 rst_n = 1'b0;
    do_reset();

    step(mk_wide(2'b10, 0, 3'b111, 0), 0, 0, 1);       // R6 unmask all
    step(mk_wide(2'b11, 0, 3'b010, 0), 0, 0, 1);       // R6 mask interrupt only
    step(mk_short(1'b1, 3'b100), 1, 0, 1);             // R4 mask abort
    step(mk_short(1'b0, 3'b010), 1, 0, 1);             // R4 unmask interrupt
    step(mk_pair(2'b00, 1, 3'b000, 5'h1F), 2, 0, 1);   // R7 mode only
    step(mk_wide(2'b11, 1, 3'b001, 5'h05), 0, 0, 1);   // R8 illegal mode, mask still set
    step(mk_wide(2'b01, 0, 3'b001, 0), 0, 0, 1);       // R10 op 01
    step(mk_wide(2'b00, 0, 3'b000, 0), 0, 0, 1);       // R10 fixed op00 M0
    step(mk_pair(2'b00, 0, 3'b000, 0), 2, 0, 1);       // R11 hint
    step(mk_short(1'b1, 3'b000), 1, 0, 1);             // R10 empty select
    step(mk_wide(2'b10, 0, 3'b000, 0), 0, 0, 1);       // R10 op1 with empty select
    step(mk_pair(2'b10, 0, 3'b001, 0), 2, 1, 1);       // R13 pair in block
    step(mk_short(1'b0, 3'b001), 1, 1, 1);             // R13 short in block
    step(mk_wide(2'b10, 0, 3'b001, 0), 0, 1, 1);       // R13 fixed unaffected
    step(mk_wide(2'b11, 0, 3'b011, 5'h1B), 0, 0, 1);   // R12 mode ignored
    step(mk_wide(2'b10, 0, 3'b111, 0), 0, 0, 0);       // R14 valid low
    step(mk_wide(2'b10, 0, 3'b111, 0), 2'd3, 0, 1);    // R2 reserved select
    step(mk_wide(2'b10, 0, 3'b111, 0) ^ 32'h0001_0000, 0, 0, 1); // R2 bad fixed bit
    step(mk_pair(2'b10, 1, 3'b111, 5'h10), 2, 0, 1);   // R7 enter user
    step(mk_wide(2'b11, 1, 3'b111, 5'h13), 0, 0, 1);   // R9 frozen
    step(mk_short(1'b1, 3'b111), 1, 0, 1);             // R9 frozen
    do_reset();

    user_wait = 0;
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] f, op;
      logic c, cd, v;
      logic [2:0] s;
      logic [4:0] m;
      logic [31:0] w;
      logic [4:0] lm [7];
      lm = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
      f  = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      op = ($urandom % 8 == 0) ? 2'($urandom) : {1'b1, 1'($urandom)};
      c  = 1'($urandom);
      s  = 3'($urandom);
      if (op == 2'b00 && ($urandom % 2 == 0)) s = 0;
      m  = c ? (($urandom % 4 != 0) ? lm[$urandom % 7] : 5'($urandom))
             : (($urandom % 6 == 0) ? 5'($urandom) : 5'h0);
      if (c && m == 5'h10 && ($urandom % 3 != 0)) m = 5'h1F;
      cd = ($urandom % 8 == 0);
      v  = ($urandom % 10 != 0);
      w  = (f == 2'd1) ? mk_short(op[0], s) : (f == 2'd2) ? mk_pair(op, c, s, m) : mk_wide(op, c, s, m);
      if ($urandom % 20 == 0) w = w ^ (32'd1 << ($urandom % 32));
      step(w, f, cd, v);
      if (!e_priv) begin
        user_wait++;
        if (user_wait > 3) begin user_wait = 0; do_reset(); end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule